// File: doc/BRIEF.md
# RMII Receive Di-bit Serializer

This block sits on the PHY side of a reduced media-independent interface. It takes receive nibbles from an upstream queue through a valid/ready handshake and presents each one on a two-bit receive bus as two di-bits, the low pair first. It drives the carrier-sense/data-valid and receive-error outputs. All three outputs are registered on the 50 MHz reference clock. At 100 Mb/s it emits one di-bit per clock. At 10 Mb/s an internal pacing counter holds every output value for a fixed number of clocks, ten by default.

Carrier sense and a symbol-error flag come from upstream decoding logic. The queue is expected to deliver the preamble and the start-of-frame delimiter as ordinary nibbles, ahead of the frame data. A preamble nibble `0x5` therefore appears as `01`,`01`, and the delimiter nibble `0xD` appears as `01`,`11`.

Carrier can fall while nibbles are still waiting in the queue. In that case the block keeps draining them, and it signals the condition by toggling carrier-sense/data-valid at the same pace as the data. After the last di-bit the bus returns to idle.

Top module: `rmii_rx_serializer`

## Requirements
- R1: A synchronous active-high reset drives `crs_dv`=0, `rxd`=00 and `rx_er`=0 from the first clock edge at which reset is sampled.
- R2: Each accepted nibble appears on `rxd` as bits [1:0] and then bits [3:2], in consecutive di-bit slots. Nibbles appear in the order they were accepted. At 100 Mb/s (`rate_10m`=0) a slot lasts one clock.
- R3: At 10 Mb/s (`rate_10m`=1), `rxd` and `crs_dv` change at most once every HOLD (default 10) clocks, and every di-bit slot lasts exactly HOLD clocks.
- R4: While `crs_in` is high, every data di-bit slot shows `crs_dv`=1.
- R5: A nibble accepted while `crs_in` is low shows `crs_dv`=0 on its first di-bit and `crs_dv`=1 on its second. Its data still appears on `rxd`.
- R6: The slot after the final di-bit of a frame, and every later slot while there is no carrier, shows `crs_dv`=0 and `rxd`=00.
- R7: At 100 Mb/s, when `err_in` and `crs_in` are both high at a slot boundary, `rx_er` is 1 during the following slot.
- R8: At 10 Mb/s `rx_er` stays 0 whatever `err_in` does.
- R9: With `crs_in` low and no frame in progress, `nib_ready` stays 0 and offered nibbles are not consumed. The outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_10m | input | 1 | 1 selects 10 Mb/s pacing, 0 selects 100 Mb/s |
| crs_in | input | 1 | Carrier sense from the receive decoder |
| err_in | input | 1 | Symbol error from the receive decoder |
| nib_valid | input | 1 | Queue holds a nibble |
| nib_data | input | 4 | Nibble at the head of the queue |
| nib_ready | output | 1 | Nibble is consumed at this clock edge |
| rxd | output | 2 | Receive di-bit |
| crs_dv | output | 1 | Carrier sense / data valid |
| rx_er | output | 1 | Receive error |

## Verification
A corrupted slot-phase bit makes the block split nibbles in the wrong order, or drop one half of a nibble. That shows on `rxd` within one di-bit slot, and `crs_dv` loses its strict low/high alternation during the drain. A wrong pacing count makes a 10 Mb/s slot shorter or longer than HOLD clocks, which is visible at the first change of any output. A stale frame-in-progress flag either consumes nibbles when there is no carrier or cuts a drain short. Either fault appears on `nib_ready` and `crs_dv` within one slot of the carrier dropping.

// File: rtl/rmii_rx_serializer.sv
module rmii_rx_serializer #(
  parameter int HOLD = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rate_10m,
  input  logic       crs_in,
  input  logic       err_in,
  input  logic       nib_valid,
  input  logic [3:0] nib_data,
  output logic       nib_ready,
  output logic [1:0] rxd,
  output logic       crs_dv,
  output logic       rx_er
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [CW-1:0] pace;
  logic          adv;
  logic          phase;
  logic          active;
  logic [1:0]    hi_q;
  logic [1:0]    rxd_q;
  logic          crs_q;
  logic          er_q;

  assign adv       = !rate_10m || (pace == CW'(HOLD - 1));
  assign nib_ready = adv && !phase && nib_valid && (crs_in || active);

  always_ff @(posedge clk) begin
    if (rst || !rate_10m || adv) pace <= '0;
    else                         pace <= pace + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      active <= 1'b0;
      hi_q   <= 2'b00;
      rxd_q  <= 2'b00;
      crs_q  <= 1'b0;
    end else if (adv) begin
      if (phase) begin
        rxd_q <= hi_q;
        crs_q <= 1'b1;
        phase <= 1'b0;
      end else if (nib_ready) begin
        rxd_q  <= nib_data[1:0];
        hi_q   <= nib_data[3:2];
        crs_q  <= crs_in;
        phase  <= 1'b1;
        active <= 1'b1;
      end else begin
        rxd_q  <= 2'b00;
        crs_q  <= crs_in;
        active <= crs_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rate_10m) er_q <= 1'b0;
    else if (adv)        er_q <= err_in && crs_in;
  end

  assign rxd    = rxd_q;
  assign crs_dv = crs_q;
  assign rx_er  = er_q;
endmodule

// File: rtl/rmii_rx_serializer_chk.sv
module rmii_rx_serializer_chk #(
  parameter int HOLD = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       rate_10m,
  input logic       crs_in,
  input logic       err_in,
  input logic       adv,
  input logic       phase,
  input logic       active,
  input logic       nib_ready,
  input logic [1:0] rxd,
  input logic       crs_dv,
  input logic       rx_er
);
  logic [2:0] prev_out;
  logic [7:0] since;
  logic       chg;

  assign chg = ({crs_dv, rxd} != prev_out);

  always_ff @(posedge clk) begin
    prev_out <= {crs_dv, rxd};
    if (rst || !rate_10m)  since <= '0;
    else if (chg)          since <= '0;
    else if (since != '1)  since <= since + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!crs_dv && rxd == 2'b00 && !rx_er));

  a_r3_hold_window: assert property (@(posedge clk) disable iff (rst)
    (rate_10m && $past(rate_10m) && $past(!rst) && chg) |-> (since >= 8'(HOLD - 1)));

  a_r5_second_dibit_valid: assert property (@(posedge clk) disable iff (rst)
    (adv && phase) |=> crs_dv);

  a_r7_err_follows: assert property (@(posedge clk) disable iff (rst)
    (adv && !rate_10m && err_in && crs_in) |=> rx_er);

  a_r8_no_err_slow: assert property (@(posedge clk) disable iff (rst)
    rate_10m |=> !rx_er);

  a_r9_no_take_idle: assert property (@(posedge clk) disable iff (rst)
    (!crs_in && !active) |-> !nib_ready);
endmodule

bind rmii_rx_serializer rmii_rx_serializer_chk #(.HOLD(HOLD)) u_chk (
  .clk(clk), .rst(rst), .rate_10m(rate_10m), .crs_in(crs_in), .err_in(err_in),
  .adv(adv), .phase(phase), .active(active), .nib_ready(nib_ready),
  .rxd(rxd), .crs_dv(crs_dv), .rx_er(rx_er)
);

// File: tb/rmii_rx_serializer_bench.sv
`timescale 1ns/1ps
module rmii_rx_serializer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rate_10m = 1'b0;
  logic       crs_in = 1'b0;
  logic       err_in = 1'b0;
  logic       nib_valid = 1'b0;
  logic [3:0] nib_data = 4'h0;
  logic       nib_ready;
  logic [1:0] rxd;
  logic       crs_dv;
  logic       rx_er;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] nibs [0:12];
  logic       tr_crs [0:511];
  logic [1:0] tr_rxd [0:511];

  always #4 clk = ~clk;

  rmii_rx_serializer u_rmii_rx_serializer (
    .clk(clk), .rst(rst), .rate_10m(rate_10m), .crs_in(crs_in), .err_in(err_in),
    .nib_valid(nib_valid), .nib_data(nib_data), .nib_ready(nib_ready),
    .rxd(rxd), .crs_dv(crs_dv), .rx_er(rx_er)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    crs_in = 0; err_in = 0; nib_valid = 0; nib_data = 0;
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    rate_10m = 0; crs_in = 1; nib_valid = 1; nib_data = 4'hA; err_in = 1;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(crs_dv == 0, "R1", crs_dv, 0, "crs_dv after reset");
    chk(rxd == 2'b00, "R1", rxd, 0, "rxd after reset");
    chk(rx_er == 0, "R1", rx_er, 0, "rx_er after reset");
    rst = 0; crs_in = 0; nib_valid = 0; err_in = 0;
  endtask

  task automatic t_frame(input logic r10, input int d);
    int n = 13;
    int step = r10 ? 10 : 1;
    int cyc = (2 * n + 4) * step + 20;
    int idx = 0;
    bit take = 0;
    int f = -1;
    rate_10m = r10;
    do_reset();
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (take) idx++;
      crs_in    = (idx < d);
      nib_valid = (idx < n);
      nib_data  = (idx < n) ? nibs[idx] : 4'h0;
      #1;
      take = nib_ready;
      tr_crs[c] = crs_dv;
      tr_rxd[c] = rxd;
    end
    crs_in = 0; nib_valid = 0;
    for (int c = 0; c < cyc; c++) if (f < 0 && tr_crs[c]) f = c;
    chk(f >= 0, "R4", f, 0, "frame start seen");
    if (f < 0) return;
    for (int k = 0; k < 2 * n + 2; k++) begin
      int s = f + k * step;
      logic ec;
      logic [1:0] er;
      string rq;
      if (k < 2 * n) begin
        ec = ((k / 2) < d) ? 1'b1 : logic'(k % 2);
        er = (k % 2) ? nibs[k/2][3:2] : nibs[k/2][1:0];
        rq = ((k / 2) < d) ? "R4" : "R5";
      end else begin
        ec = 1'b0; er = 2'b00; rq = "R6";
      end
      chk(tr_crs[s] == ec, rq, tr_crs[s], ec, $sformatf("crs_dv slot %0d", k));
      chk(tr_rxd[s] == er, (k < 2 * n) ? "R2" : "R6", tr_rxd[s], er, $sformatf("rxd slot %0d", k));
      if (step > 1 && k <= 2 * n) begin
        bit stable = 1;
        for (int j = 1; j < step; j++)
          if (tr_crs[s+j] != tr_crs[s] || tr_rxd[s+j] != tr_rxd[s]) stable = 0;
        chk(stable, "R3", stable, 1, $sformatf("slot %0d held", k));
      end
    end
  endtask

  task automatic t_err();
    bit er_ok = 1;
    rate_10m = 0;
    do_reset();
    crs_in = 1; err_in = 1;
    @(negedge clk); @(negedge clk);
    chk(rx_er == 1, "R7", rx_er, 1, "rx_er raised at 100M");
    err_in = 0;
    @(negedge clk); @(negedge clk);
    chk(rx_er == 0, "R7", rx_er, 0, "rx_er cleared at 100M");
    rate_10m = 1;
    do_reset();
    crs_in = 1; err_in = 1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (rx_er) er_ok = 0;
    end
    chk(er_ok, "R8", er_ok, 1, "rx_er low at 10M");
    crs_in = 0; err_in = 0;
  endtask

  task automatic t_nocarrier();
    bit ok = 1;
    rate_10m = 0;
    do_reset();
    nib_valid = 1; nib_data = 4'hF; crs_in = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); #1;
      if (nib_ready || crs_dv || rxd != 2'b00) ok = 0;
    end
    chk(ok, "R9", ok, 1, "no take without carrier");
    nib_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) nibs[i] = 4'h5;
    nibs[4] = 4'h5; nibs[5] = 4'hD;
    nibs[6] = 4'hA; nibs[7] = 4'h3; nibs[8] = 4'hC; nibs[9] = 4'h6;
    nibs[10] = 4'hF; nibs[11] = 4'h0; nibs[12] = 4'h9;
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_frame(1'b0, 13);
    t_frame(1'b0, 10);
    t_frame(1'b1, 13);
    t_frame(1'b1, 11);
    t_err();
    t_nocarrier();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule